// File: doc/BRIEF.md
# Paged Nonvolatile Write Load Controller

This block is the write-side front end of a byte-wide paged memory that looks like a static RAM to its host. Three active-low strobes (chip select, output enable, write strobe) are sampled on the system clock. A write pulse needs chip select and write strobe both low while output enable is high, held for a minimum number of sampled cycles. Each qualified pulse loads one byte into a page buffer and sets that byte's valid bit. The address comes from the first cycle of the pulse and the data from its last cycle.

The first accepted byte opens a load window and latches the page number. Further bytes of the same page may follow in any order, and a byte loaded again replaces its earlier value. If no accepted byte arrives for a set number of cycles, the window closes. A timed programming phase then copies only the valid bytes into a behavioural storage array, one buffer slot per cycle, while `busy` is high. When programming ends, the valid mask is cleared and the controller waits for a new first byte.

A strobe that names a different page while a window is open is dropped and sets a sticky error flag. Reads use chip select and output enable low with the write strobe high, and return the stored byte one cycle later. `PROG_CYC` must be at least `2**PAGE_BITS`.

Top module: `pgwr_ctrl`

## Requirements
- R1: A byte load happens only when `ce_n` and `we_n` are both sampled low, with `oe_n` high, for at least `MIN_PULSE` consecutive clock edges, and the pulse then ends. Either strobe may fall last or rise first.
- R2: The address is taken from the first edge at which both strobes are low. The data is taken from the last such edge. Address or data changes in between have no effect.
- R3: A pulse shorter than `MIN_PULSE` sampled edges, or one during which `oe_n` is sampled low, loads nothing. It does not open a window.
- R4: `addr[PAGE_BITS-1:0]` selects the byte within the page and `addr[ADDR_W-1:PAGE_BITS]` selects the page. The first accepted byte latches the page.
- R5: Bytes of the open page may be loaded in any order. A byte loaded twice in one window keeps the later value.
- R6: Let E be the clock edge that registers the last accepted byte, which is one edge after the edge that first samples the pulse released. `busy` rises `LOAD_TMO` edges after E, provided no further byte is accepted in that time.
- R7: `busy` stays high for exactly `PROG_CYC` cycles. Write pulses that end while `busy` is high are ignored.
- R8: Programming writes only the loaded bytes of the latched page. Every other location keeps its value. Once `busy` falls, the valid mask is empty and a new window can open.
- R9: A pulse in an open window whose page differs from the latched page is ignored. It does not restart the timeout, and it sets `page_err`, which stays high until reset.
- R10: On an edge where `ce_n` and `oe_n` are low and `we_n` is high, `dout` takes the stored byte at `addr`. On any other edge, `dout` becomes 0. Reset clears `busy`, `page_err` and `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, slot in the low `PAGE_BITS` bits |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | Sticky flag for a wrong-page strobe inside a window |

## Verification
The assertions assume the strobes, address and data are synchronous to `clk`, as if already synchronised upstream. They also assume that no wrong-page pulse ends during the last `LOAD_TMO` cycles before a window times out, since the timeout check measures from any registered load event. The stimulus changes inputs only on falling clock edges. It spaces byte loads about seven cycles apart, far inside the timeout. Every pulse that overlaps programming starts and ends while `busy` is still high, and wrong-page pulses are always followed by an accepted byte of the open page.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_LOAD = 2'd1,
    PG_PROG = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgwr_strobe.sv
// Strobe qualifier: turns a sampled chip-select/write-strobe pulse into a
// one-cycle load event carrying the captured address and data.
module pgwr_strobe #(
  parameter int AW        = 10,
  parameter int DW        = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          fire,
  output logic [AW-1:0] fire_addr,
  output logic [DW-1:0] fire_data
);
  localparam int CW = (MIN_PULSE < 1) ? 1 : $clog2(MIN_PULSE + 1);

  logic          act_q, act_d;
  logic          void_q, void_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] a_q, a_d, fa_q, fa_d;
  logic [DW-1:0] d_q, d_d, fd_q, fd_d;
  logic          fire_q, fire_d;
  logic          both_low;

  assign both_low = ~ce_n & ~we_n;

  always_comb begin
    act_d  = act_q;
    void_d = void_q;
    cnt_d  = cnt_q;
    a_d    = a_q;
    d_d    = d_q;
    fa_d   = fa_q;
    fd_d   = fd_q;
    fire_d = 1'b0;
    if (both_low) begin
      d_d = din;
      if (!act_q) begin
        act_d  = 1'b1;
        cnt_d  = CW'(1);
        a_d    = addr;
        void_d = ~oe_n;
      end else begin
        void_d = void_q | ~oe_n;
        if (cnt_q < CW'(MIN_PULSE)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (act_q) begin
      act_d  = 1'b0;
      fire_d = (cnt_q >= CW'(MIN_PULSE)) & ~void_q;
      fa_d   = a_q;
      fd_d   = d_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      void_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      d_q    <= '0;
      fa_q   <= '0;
      fd_q   <= '0;
      fire_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      void_q <= void_d;
      cnt_q  <= cnt_d;
      a_q    <= a_d;
      d_q    <= d_d;
      fa_q   <= fa_d;
      fd_q   <= fd_d;
      fire_q <= fire_d;
    end
  end

  assign fire      = fire_q;
  assign fire_addr = fa_q;
  assign fire_data = fd_q;
endmodule

// File: rtl/pgwr_pagebuf.sv
// Page buffer: one data slot per byte of the page plus a valid mask.
module pgwr_pagebuf #(
  parameter int DW = 8,
  parameter int PB = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PB-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic                clr,
  input  logic [PB-1:0]       rd_idx,
  output logic [DW-1:0]       rd_data,
  output logic [(1<<PB)-1:0]  vmask
);
  localparam int PAGE_SZ = 1 << PB;

  logic [DW-1:0]      slot_q [PAGE_SZ];
  logic [PAGE_SZ-1:0] vm_q, vm_d;

  for (genvar i = 0; i < PAGE_SZ; i++) begin : g_vbit
    assign vm_d[i] = clr ? 1'b0
                   : ((wr_en && (wr_idx == PB'(i))) ? 1'b1 : vm_q[i]);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_q[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vm_q <= '0;
    end else begin
      vm_q <= vm_d;
    end
  end

  assign rd_data = slot_q[rd_idx];
  assign vmask   = vm_q;
endmodule

// File: rtl/pgwr_array.sv
// Behavioural storage array with one write port and one registered read port.
module pgwr_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];
  logic [DW-1:0] rd_q, rd_d;

  always_ff @(posedge clk) begin
    if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rd_d = re ? cell_q[raddr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/pgwr_ctrl.sv
// Top: load window, byte-load timeout, programming timer and commit walker.
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7,
  parameter int MIN_PULSE = 2,
  parameter int LOAD_TMO  = 64,
  parameter int PROG_CYC  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int PG_W    = ADDR_W - PAGE_BITS;
  localparam int TW      = $clog2(LOAD_TMO + 1);
  localparam int PW      = $clog2(PROG_CYC + 1);

  pg_state_e st_q, st_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [TW-1:0]     tmo_q, tmo_d;
  logic [PW-1:0]     prog_q, prog_d;
  logic              err_q, err_d;

  logic              stb_fire;
  logic [ADDR_W-1:0] stb_addr;
  logic [DATA_W-1:0] stb_data;
  logic [PG_W-1:0]   f_page;
  logic [PAGE_BITS-1:0] f_idx;

  logic              buf_we, buf_clr;
  logic [PAGE_BITS-1:0] walk_idx;
  logic [DATA_W-1:0] walk_data;
  logic [PAGE_SZ-1:0] vmask;
  logic              mem_we, rd_en;

  pgwr_strobe #(
    .AW(ADDR_W), .DW(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) u_stb (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din),
    .fire(stb_fire), .fire_addr(stb_addr), .fire_data(stb_data)
  );

  assign f_page = stb_addr[ADDR_W-1:PAGE_BITS];
  assign f_idx  = stb_addr[PAGE_BITS-1:0];

  always_comb begin
    st_d    = st_q;
    page_d  = page_q;
    tmo_d   = tmo_q;
    prog_d  = prog_q;
    err_d   = err_q;
    buf_we  = 1'b0;
    buf_clr = 1'b0;
    case (st_q)
      PG_IDLE: begin
        if (stb_fire) begin
          st_d   = PG_LOAD;
          page_d = f_page;
          tmo_d  = '0;
          buf_we = 1'b1;
        end
      end
      PG_LOAD: begin
        if (stb_fire && (f_page == page_q)) begin
          buf_we = 1'b1;
          tmo_d  = '0;
        end else begin
          if (stb_fire) begin
            err_d = 1'b1;
          end
          if (tmo_q == TW'(LOAD_TMO - 1)) begin
            st_d   = PG_PROG;
            prog_d = '0;
          end else begin
            tmo_d = tmo_q + 1'b1;
          end
        end
      end
      PG_PROG: begin
        if (prog_q == PW'(PROG_CYC - 1)) begin
          st_d    = PG_IDLE;
          buf_clr = 1'b1;
        end else begin
          prog_d = prog_q + 1'b1;
        end
      end
      default: begin
        st_d = PG_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PG_IDLE;
      page_q <= '0;
      tmo_q  <= '0;
      prog_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
      tmo_q  <= tmo_d;
      prog_q <= prog_d;
      err_q  <= err_d;
    end
  end

  pgwr_pagebuf #(
    .DW(DATA_W), .PB(PAGE_BITS)
  ) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_we), .wr_idx(f_idx), .wr_data(stb_data),
    .clr(buf_clr), .rd_idx(walk_idx), .rd_data(walk_data),
    .vmask(vmask)
  );

  // Commit walker: slot k is visited in programming cycle k.
  assign walk_idx = prog_q[PAGE_BITS-1:0];
  assign mem_we   = (st_q == PG_PROG) && (prog_q < PW'(PAGE_SZ)) && vmask[walk_idx];
  assign rd_en    = ~ce_n & ~oe_n & we_n;

  pgwr_array #(
    .AW(ADDR_W), .DW(DATA_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr({page_q, walk_idx}), .wdata(walk_data),
    .re(rd_en), .raddr(addr), .rdata(dout)
  );

  assign busy     = (st_q == PG_PROG);
  assign page_err = err_q;
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
  parameter int PAGE_SZ  = 128,
  parameter int LOAD_TMO = 64,
  parameter int PROG_CYC = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               page_err,
  input logic               ld_fire,
  input logic [PAGE_SZ-1:0] vmask
);
  int unsigned run_q;
  int unsigned since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 0;
      since_q <= 0;
    end else begin
      run_q <= busy ? run_q + 1 : 0;
      if (ld_fire) since_q <= 0;
      else if (since_q < LOAD_TMO + 4) since_q <= since_q + 1;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> !ld_fire); // R1
  AST_LOAD_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> since_q >= LOAD_TMO); // R6
  AST_PROG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == PROG_CYC); // R7
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vmask)); // R7
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> vmask == '0); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err); // R9
endmodule

bind pgwr_ctrl pgwr_chk #(
  .PAGE_SZ(PAGE_SZ), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .page_err(page_err),
  .ld_fire(stb_fire), .vmask(vmask)
);

// File: tb/sim_pgwr_ctrl.sv
module sim_pgwr_ctrl;
  localparam int CLK_PER   = 10;
  localparam int AW        = 10;
  localparam int PB        = 7;
  localparam int MINP      = 2;
  localparam int LTMO      = 64;
  localparam int PCYC      = 256;

  logic clk, rst_n, ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic busy, page_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pgwr_ctrl #(
    .ADDR_W(AW), .DATA_W(8), .PAGE_BITS(PB), .MIN_PULSE(MINP),
    .LOAD_TMO(LTMO), .PROG_CYC(PCYC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PER/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0] mem_m [int];
  bit [7:0] pbuf [int];
  int m_st, m_tmo, m_prog, m_page, m_err, m_run;
  int s_act, s_cnt, s_void, s_a, s_d;
  int pf, pa, pd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tmo = 0; m_prog = 0; m_page = 0; m_err = 0; m_run = 0;
      s_act = 0; s_cnt = 0; s_void = 0; s_a = 0; s_d = 0;
      pf = 0; pa = 0; pd = 0;
      pbuf.delete();
    end else begin
      m_run = 1;
      case (m_st)
        0: if (pf != 0) begin
             m_page = pa >> PB; pbuf.delete(); pbuf[pa % (1 << PB)] = pd[7:0];
             m_tmo = 0; m_st = 1;
           end
        1: if (pf != 0 && (pa >> PB) == m_page) begin
             pbuf[pa % (1 << PB)] = pd[7:0]; m_tmo = 0;
           end else begin
             if (pf != 0) m_err = 1;
             if (m_tmo == LTMO - 1) begin
               foreach (pbuf[k]) mem_m[(m_page << PB) + k] = pbuf[k];
               pbuf.delete(); m_st = 2; m_prog = 0;
             end else m_tmo++;
           end
        default: if (m_prog == PCYC - 1) m_st = 0; else m_prog++;
      endcase
      pf = 0;
      if (!ce_n && !we_n) begin
        s_d = int'(din);
        if (s_act == 0) begin
          s_act = 1; s_cnt = 1; s_a = int'(addr); s_void = !oe_n;
        end else begin
          s_cnt++; if (!oe_n) s_void = 1;
        end
      end else if (s_act != 0) begin
        s_act = 0;
        pf = (s_cnt >= MINP && s_void == 0) ? 1 : 0;
        pa = s_a; pd = s_d;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_run != 0 && !done) begin
      chk(busy == (m_st == 2), "R6/R7 busy timing", int'(busy), int'(m_st == 2));
      chk(page_err == (m_err != 0), "R9 page_err", int'(page_err), m_err);
    end
  end

  // ---------------- stimulus tasks ----------------
  // mode 0: write strobe falls last / rises first; mode 1: chip select does.
  task automatic wr(input int a, input int d, input int mode, input int hold, input bit oe_dip);
    @(negedge clk);
    addr = AW'(a); din = ~d[7:0];
    if (mode == 0) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk);
    if (mode == 0) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk);
    din = d[7:0];
    if (hold >= 2) addr = AW'(a ^ 1);   // R2: later address change ignored
    if (oe_dip) oe_n = 1'b0;
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      oe_n = 1'b1;
    end
    oe_n = 1'b1;
    if (mode == 0) we_n = 1'b1; else ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    if (mem_m.exists(a))
      chk(dout == mem_m[a], req, int'(dout), int'(mem_m[a]));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle;
    idle(LTMO + PCYC + 10);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int len;
    int wait_n;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    chk(page_err == 1'b0, "R10 reset page_err", int'(page_err), 0);
    chk(dout == 8'h00, "R10 reset dout", int'(dout), 0);
    rst_n = 1'b1;
    idle(4);

    // R1 R2 R4: full page 1, alternating strobe order
    for (int i = 0; i < 128; i++) wr(128 + i, (i * 7 + 3) & 255, i % 2, 2 + (i % 2), 1'b0);
    settle();
    for (int i = 0; i < 128; i++) rd_chk(128 + i, "R1/R2/R4 full page");

    // page 3 seed bytes, also measures the programming length (R7)
    for (int i = 0; i < 4; i++) wr(384 + i, i ^ 8'h5A, 0, 2, 1'b0);
    wait_n = 0;
    while (!busy && wait_n < LTMO + 20) begin @(negedge clk); wait_n++; end
    len = 0;
    while (busy && len < PCYC + 20) begin @(negedge clk); len++; end
    chk(len == PCYC, "R7 busy length", len, PCYC);
    idle(5);

    // R5 R8: partial page, out of order, overwrite
    wr(128 + 90, 11, 0, 2, 1'b0);
    wr(128 + 4, 22, 1, 3, 1'b0);
    wr(128 + 90, 33, 0, 2, 1'b0);
    wr(128 + 127, 44, 1, 2, 1'b0);
    settle();
    chk(mem_m[128 + 90] == 8'd33, "R5 model overwrite", int'(mem_m[128 + 90]), 33);
    for (int i = 0; i < 128; i++) rd_chk(128 + i, "R5/R8 partial page");

    // R3: short pulse and output-enable dip both load nothing
    wr(128 + 10, 8'hEE, 0, 1, 1'b0);
    idle(LTMO + 10);
    chk(busy == 1'b0, "R3 short pulse no window", int'(busy), 0);
    rd_chk(128 + 10, "R3 short pulse data kept");
    wr(128 + 11, 8'hDD, 1, 3, 1'b1);
    idle(LTMO + 10);
    chk(busy == 1'b0, "R3 oe dip no window", int'(busy), 0);
    rd_chk(128 + 11, "R3 oe dip data kept");

    // R9: wrong page ignored, flag sticky
    wr(256 + 0, 8'h77, 0, 2, 1'b0);
    wr(384 + 1, 8'h99, 1, 2, 1'b0);
    wr(256 + 5, 8'h66, 0, 2, 1'b0);
    settle();
    chk(page_err == 1'b1, "R9 flag set", int'(page_err), 1);
    rd_chk(384 + 1, "R9 wrong page untouched");
    rd_chk(256 + 0, "R9 open page byte 0");
    rd_chk(256 + 5, "R9 open page byte 5");

    // R7: strobe during programming ignored; R8: new window afterwards
    wr(128 + 20, 8'h12, 0, 2, 1'b0);
    wait_n = 0;
    while (!busy && wait_n < LTMO + 20) begin @(negedge clk); wait_n++; end
    idle(3);
    wr(128 + 21, 8'h34, 1, 2, 1'b0);
    settle();
    chk(busy == 1'b0, "R7 no window after busy strobe", int'(busy), 0);
    rd_chk(128 + 21, "R7 busy strobe ignored");
    rd_chk(128 + 20, "R8 byte committed");
    wr(128 + 22, 8'h56, 0, 2, 1'b0);
    settle();
    rd_chk(128 + 22, "R8 new window");
    rd_chk(128 + 90, "R8 earlier data kept");
    chk(page_err == 1'b1, "R9 still sticky", int'(page_err), 1);
    idle(2);
    chk(dout == 8'h00, "R10 dout idle zero", int'(dout), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule